// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small accumulator processor that runs programs out of one shared 32-word memory, one step at a time. Each instruction passes through fetch, decode and execute states. Every step moves a value between named registers: the program counter, the memory address latch, the memory data latch, the instruction latch and the accumulator. Memory is reached through an address bus, an outbound data bus, an inbound data bus and separate read and write strobes. The memory answers a read one clock after the strobe.

The instruction set has five instructions: load, store, add, subtract and halt. Each one names a single direct memory operand. A program is placed in memory from address 0 and the processor is released from reset. It then runs until it reaches a halt instruction. After that, the accumulator output and the memory contents hold the results. Each instruction takes a fixed number of cycles, so the time to the halt can be worked out from the program alone.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and accumulator are cleared to 0, and `mem_rd`, `mem_wr` and `halted` are all low.
- R2: A fetch copies the program counter to the address latch. On the next cycle `mem_rd` is high for exactly one cycle with `mem_addr` equal to that counter value. The word read is taken one cycle after the strobe, so the first fetch strobe appears in the first cycle after reset is released, at address 0.
- R3: The program counter advances by exactly one for each instruction fetched, and it changes in no other way. After a halt it holds the halt word's address plus one.
- R4: An instruction word carries the opcode in bits 7:5 and a direct memory address in bits 4:0. The opcodes are 001 load, 010 store, 011 add, 100 subtract and 111 halt.
- R5: Load reads the addressed word into the accumulator through the data latch. It takes 10 cycles from the start of its fetch to the start of the next fetch.
- R6: Store writes the accumulator to the addressed word with a write strobe one cycle wide. It takes 8 cycles.
- R7: Add sets the accumulator to the accumulator plus the memory operand, modulo 256. It takes 10 cycles.
- R8: Subtract sets the accumulator to the accumulator minus the memory operand, modulo 256. It takes 10 cycles.
- R9: The opcodes 000, 101 and 110 do nothing. They take 6 cycles, leave the accumulator and memory unchanged, and execution goes on with the next word.
- R10: Halt raises `halted` 6 cycles after its fetch starts. From then on `halted` stays high, no strobe is asserted, and the program counter and accumulator hold their values.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Read data returned by memory one cycle after a read strobe |
| mem_addr | output | 5 | Memory address, driven from the address latch |
| mem_wdata | output | 8 | Write data, driven from the data latch |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt has executed |
| acc_out | output | 8 | Accumulator value |
| pc_out | output | 5 | Program counter value |

## Verification
A memory operation costs 10 cycles, a store 8, and a no-op or halt 6, each counted from the start of its fetch. The `halted` output should therefore first rise after exactly the sum of these costs over the program. The bench counts clock edges from the release of reset and compares that count with a sum it computes from each word's opcode. All outputs are sampled on the falling edge that follows each rising edge. The first read strobe is checked one edge after release. Accumulator, program counter and memory contents are read only after `halted` is seen, and the strobe counts are collected at every rising edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W   = 3;
    localparam int ADDR_W = 5;
    localparam int DATA_W = OP_W + ADDR_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OP_W-1:0]   opc_t;

    localparam opc_t OPC_LOAD  = 3'b001;
    localparam opc_t OPC_STORE = 3'b010;
    localparam opc_t OPC_ADD   = 3'b011;
    localparam opc_t OPC_SUB   = 3'b100;
    localparam opc_t OPC_HALT  = 3'b111;

    typedef enum logic [2:0] {
        K_NOP, K_LOAD, K_STORE, K_ADD, K_SUB, K_HALT
    } kind_e;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_RD, ST_F_WAIT, ST_F_CIR, ST_F_INC, ST_DECODE,
        ST_X_MAR, ST_X_RD, ST_X_WAIT, ST_X_ALU, ST_X_WR, ST_HALT
    } state_e;

    typedef struct packed {
        logic pc_to_mar;
        logic cir_to_mar;
        logic acc_to_mdr;
        logic bus_to_mdr;
        logic mdr_to_cir;
        logic pc_inc;
        logic acc_from_mdr;
        logic acc_from_alu;
        logic alu_sub;
        logic rd;
        logic wr;
        logic halt;
    } ctrl_t;

    function automatic opc_t opc_of(input word_t w);
        return w[DATA_W-1 -: OP_W];
    endfunction

    function automatic addr_t addr_of(input word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic kind_e classify(input opc_t op);
        case (op)
            OPC_LOAD:  return K_LOAD;
            OPC_STORE: return K_STORE;
            OPC_ADD:   return K_ADD;
            OPC_SUB:   return K_SUB;
            OPC_HALT:  return K_HALT;
            default:   return K_NOP;
        endcase
    endfunction

    function automatic word_t alu_eval(input word_t a, input word_t b, input logic sub);
        return sub ? word_t'(a - b) : word_t'(a + b);
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  word_t lhs,
    input  word_t rhs,
    input  logic  sub,
    output word_t res
);
    // Result wraps to the word width in both directions.
    assign res = alu_eval(lhs, rhs, sub);
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  word_t mem_rdata,
    output addr_t mar_q,
    output word_t mdr_q,
    output opc_t  opcode,
    output word_t acc_q,
    output addr_t pc_q
);
    word_t cir_q;
    word_t alu_res;

    acc_cpu_alu alu_i (
        .lhs (acc_q),
        .rhs (mdr_q),
        .sub (ctrl.alu_sub),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst)                pc_q <= '0;
        else if (ctrl.pc_inc)   pc_q <= addr_t'(pc_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst)                  mar_q <= '0;
        else if (ctrl.pc_to_mar)  mar_q <= pc_q;
        else if (ctrl.cir_to_mar) mar_q <= addr_of(cir_q);
    end

    always_ff @(posedge clk) begin
        if (rst)                  mdr_q <= '0;
        else if (ctrl.bus_to_mdr) mdr_q <= mem_rdata;
        else if (ctrl.acc_to_mdr) mdr_q <= acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                  cir_q <= '0;
        else if (ctrl.mdr_to_cir) cir_q <= mdr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                    acc_q <= '0;
        else if (ctrl.acc_from_mdr) acc_q <= mdr_q;
        else if (ctrl.acc_from_alu) acc_q <= alu_res;
    end

    assign opcode = opc_of(cir_q);
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opc_t  opcode,
    output ctrl_t ctrl
);
    state_e st, st_nx;
    kind_e  kind;

    assign kind = classify(opcode);

    always_ff @(posedge clk) begin
        if (rst) st <= ST_F_MAR;
        else     st <= st_nx;
    end

    always_comb begin
        case (st)
            ST_F_MAR:  st_nx = ST_F_RD;
            ST_F_RD:   st_nx = ST_F_WAIT;
            ST_F_WAIT: st_nx = ST_F_CIR;
            ST_F_CIR:  st_nx = ST_F_INC;
            ST_F_INC:  st_nx = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    K_HALT:  st_nx = ST_HALT;
                    K_NOP:   st_nx = ST_F_MAR;
                    default: st_nx = ST_X_MAR;
                endcase
            end
            ST_X_MAR:  st_nx = (kind == K_STORE) ? ST_X_WR : ST_X_RD;
            ST_X_RD:   st_nx = ST_X_WAIT;
            ST_X_WAIT: st_nx = ST_X_ALU;
            ST_X_ALU:  st_nx = ST_F_MAR;
            ST_X_WR:   st_nx = ST_F_MAR;
            ST_HALT:   st_nx = ST_HALT;
            default:   st_nx = ST_F_MAR;
        endcase
    end

    always_comb begin
        ctrl = '0;
        case (st)
            ST_F_MAR:  ctrl.pc_to_mar  = 1'b1;
            ST_F_RD:   ctrl.rd         = 1'b1;
            ST_F_WAIT: ctrl.bus_to_mdr = 1'b1;
            ST_F_CIR:  ctrl.mdr_to_cir = 1'b1;
            ST_F_INC:  ctrl.pc_inc     = 1'b1;
            ST_X_MAR: begin
                ctrl.cir_to_mar = 1'b1;
                ctrl.acc_to_mdr = (kind == K_STORE);
            end
            ST_X_RD:   ctrl.rd         = 1'b1;
            ST_X_WAIT: ctrl.bus_to_mdr = 1'b1;
            ST_X_ALU: begin
                ctrl.acc_from_mdr = (kind == K_LOAD);
                ctrl.acc_from_alu = (kind == K_ADD) || (kind == K_SUB);
                ctrl.alu_sub      = (kind == K_SUB);
            end
            ST_X_WR:   ctrl.wr   = 1'b1;
            ST_HALT:   ctrl.halt = 1'b1;
            default:   ctrl = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out
);
    ctrl_t ctrl;
    opc_t  opcode;
    addr_t mar_q;
    word_t mdr_q;
    word_t acc_q;
    addr_t pc_q;

    acc_cpu_ctrl ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    acc_cpu_dp dp_i (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .mar_q     (mar_q),
        .mdr_q     (mdr_q),
        .opcode    (opcode),
        .acc_q     (acc_q),
        .pc_q      (pc_q)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_rd    = ctrl.rd;
    assign mem_wr    = ctrl.wr;
    assign halted    = ctrl.halt;
    assign acc_out   = acc_q;
    assign pc_out    = pc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] acc_out
);
    assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_rd_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_wr_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    assert_pc_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_out) |-> (ADDR_W'(pc_out - $past(pc_out)) == ADDR_W'(1)));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    assert_halt_holds_state_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_out) && $stable(acc_out)));
endmodule

bind acc_cpu acc_cpu_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .halted  (halted),
    .pc_out  (pc_out),
    .acc_out (acc_out)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_rdata;
    logic [4:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_rd, mem_wr, halted;
    logic [7:0] acc_out;
    logic [4:0] pc_out;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;

    logic [7:0] mem [32];

    // 4 ns period
    always #2 clk = ~clk;

    acc_cpu dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted),
        .acc_out   (acc_out),
        .pc_out    (pc_out)
    );

    // Synchronous memory, one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Strobe counters, sampled at the rising edge on pre-edge values.
    always @(posedge clk) begin
        if (!rst && mem_rd) rd_cnt = rd_cnt + 1;
        if (!rst && mem_wr) wr_cnt = wr_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [2:0] op, input logic [4:0] a);
        return {op, a};
    endfunction

    // Per-instruction cycle cost from R5..R10.
    function automatic int cost(input logic [7:0] w);
        case (w[7:5])
            3'b001, 3'b011, 3'b100: return 10;
            3'b010:                 return 8;
            default:                return 6;
        endcase
    endfunction

    function automatic int prog_cycles();
        int total = 0;
        for (int i = 0; i < 32; i++) begin
            total += cost(mem[i]);
            if (mem[i][7:5] == 3'b111) return total;
        end
        return total;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    endtask

    // Reset, release, count edges until halted is seen.
    task automatic run_prog(input string req, input int exp_reads, input int exp_writes);
        int cyc;
        int exp_cyc;
        exp_cyc = prog_cycles();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        rst = 1'b0;
        cyc = 0;
        while (cyc < 500) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
        check(cyc == exp_cyc, req, "cycles to halted", cyc, exp_cyc);
        check(rd_cnt == exp_reads, "R2", "read strobe cycles", rd_cnt, exp_reads);
        check(wr_cnt == exp_writes, "R6", "write strobe cycles", wr_cnt, exp_writes);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = enc(3'b111, 5'd0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pc_out == 5'd0, "R1", "pc in reset", pc_out, 0);
        check(acc_out == 8'd0, "R1", "acc in reset", acc_out, 0);
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        check(!halted, "R1", "halted in reset", halted, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(mem_rd == 1'b1, "R2", "first fetch strobe", mem_rd, 1);
        check(mem_addr == 5'd0, "R2", "first fetch address", mem_addr, 0);
        @(posedge clk);
        @(negedge clk);
        check(mem_rd == 1'b0, "R2", "strobe one cycle wide", mem_rd, 0);
    endtask

    task automatic t_load_halt();
        clear_mem();
        mem[0]  = enc(3'b001, 5'd20);
        mem[1]  = enc(3'b111, 5'd0);
        mem[20] = 8'h5A;
        run_prog("R5", 3, 0);
        check(acc_out == 8'h5A, "R5", "acc after load", acc_out, 8'h5A);
        check(pc_out == 5'd2, "R3", "pc after halt", pc_out, 2);
    endtask

    task automatic t_add_wrap();
        logic [7:0] exp;
        clear_mem();
        mem[0]  = enc(3'b001, 5'd20);
        mem[1]  = enc(3'b011, 5'd21);
        mem[2]  = enc(3'b010, 5'd22);
        mem[3]  = enc(3'b111, 5'd0);
        mem[20] = 8'hF0;
        mem[21] = 8'h25;
        exp = 8'(8'hF0 + 8'h25);
        run_prog("R7", 6, 1);
        check(acc_out == exp, "R7", "acc after add wrap", acc_out, exp);
        check(mem[22] == exp, "R6", "stored word", mem[22], exp);
        check(pc_out == 5'd4, "R3", "pc after halt", pc_out, 4);
    endtask

    task automatic t_sub_wrap();
        logic [7:0] exp;
        clear_mem();
        mem[0]  = enc(3'b001, 5'd20);
        mem[1]  = enc(3'b100, 5'd21);
        mem[2]  = enc(3'b010, 5'd23);
        mem[3]  = enc(3'b111, 5'd0);
        mem[20] = 8'h03;
        mem[21] = 8'h05;
        exp = 8'(8'h03 - 8'h05);
        run_prog("R8", 6, 1);
        check(acc_out == exp, "R8", "acc after sub wrap", acc_out, exp);
        check(mem[23] == exp, "R6", "stored word", mem[23], exp);
        check(mem[22] == 8'h00, "R6", "neighbour untouched", mem[22], 0);
    endtask

    task automatic t_store_twice();
        clear_mem();
        mem[0]  = enc(3'b001, 5'd30);
        mem[1]  = enc(3'b010, 5'd31);
        mem[2]  = enc(3'b011, 5'd31);
        mem[3]  = enc(3'b010, 5'd29);
        mem[4]  = enc(3'b111, 5'd0);
        mem[30] = 8'h41;
        run_prog("R6", 7, 2);
        check(mem[31] == 8'h41, "R6", "first store", mem[31], 8'h41);
        check(mem[29] == 8'h82, "R7", "store after add", mem[29], 8'h82);
    endtask

    task automatic t_nops();
        clear_mem();
        mem[0]  = enc(3'b001, 5'd20);
        mem[1]  = enc(3'b000, 5'd20);
        mem[2]  = enc(3'b101, 5'd21);
        mem[3]  = enc(3'b110, 5'd22);
        mem[4]  = enc(3'b111, 5'd0);
        mem[20] = 8'h11;
        mem[21] = 8'h22;
        mem[22] = 8'h33;
        run_prog("R9", 6, 0);
        check(acc_out == 8'h11, "R9", "acc after no-ops", acc_out, 8'h11);
        check(mem[20] == 8'h11 && mem[21] == 8'h22 && mem[22] == 8'h33,
              "R9", "memory after no-ops", {mem[20], mem[21], mem[22]}, 24'h112233);
        check(pc_out == 5'd5, "R9", "pc passes no-ops", pc_out, 5);
    endtask

    task automatic t_halt_hold();
        logic [4:0] pc0;
        logic [7:0] acc0;
        clear_mem();
        mem[0]  = enc(3'b001, 5'd9);
        mem[1]  = enc(3'b111, 5'd0);
        mem[2]  = enc(3'b010, 5'd9);
        mem[9]  = 8'hC3;
        run_prog("R10", 3, 0);
        pc0  = pc_out;
        acc0 = acc_out;
        rd_cnt = 0;
        wr_cnt = 0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(halted == 1'b1, "R10", "halted stays high", halted, 1);
        check(rd_cnt == 0 && wr_cnt == 0, "R10", "no strobes after halt",
              rd_cnt + wr_cnt, 0);
        check(pc_out == pc0 && acc_out == acc0, "R10", "pc and acc hold",
              {pc_out, acc_out}, {pc0, acc0});
        check(mem[9] == 8'hC3, "R10", "word after halt not executed", mem[9], 8'hC3);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_load_halt();
        t_add_wrap();
        t_sub_wrap();
        t_store_twice();
        t_nops();
        t_halt_hold();
        // R4 and R11 are covered by the encodings used above and the checker.
        finish_run();
    end

endmodule